// File: doc/BRIEF.md
# Converter Serial Readout Register

This block is the digital back end of a sampling converter that an external host reads over a two-wire serial link. The converter core is outside the block. The host pulls an active-low convert-start input low to begin a conversion. The block then raises a busy flag for a fixed number of system clock cycles, set by a parameter. While busy is high, the converter core hands over its 14-bit result on a parallel bus, marked by a one-cycle valid pulse. When busy drops, that result is placed in a 16-bit output word with two zero bits in front of it. The word then waits for the host.

The host supplies the serial clock. The block moves one bit per rising edge of that clock, most significant bit first. The first bit is already on the data line before any edge arrives, so the host can sample on falling edges. The host may stop its clock between groups of bits for as long as it likes, and no position is lost. When all sixteen bits have gone out, the data line stays low.

The serial clock and convert-start pins are synchronized into the system clock domain before any edge is detected. A falling edge on convert-start also resynchronizes the readout: if the serial clock is low at that moment, the bit position and the output word are cleared. If the serial clock is high, both are left alone. The serial clock has to stay low while a conversion is running.

Top module: `adc_serial_readout`

## Requirements
- R1: The output word is 16 bits wide. Bits 15 and 14 are zero and bits 13..0 carry the conversion result, so the first two bits read after a load are always 0.
- R2: Bits leave most significant first. The bit at position 15 is driven as soon as busy falls, and each synchronized rising edge of the serial clock moves the data line on to the next lower bit. Nothing else changes the data line except a load or a clear.
- R3: A synchronized falling edge of `conv_start_n` while idle raises busy. Busy then stays high for exactly CONV_CYCLES system clock cycles.
- R4: When busy falls, the word is loaded from the result of the most recent `result_valid` pulse. If there was no pulse during the conversion, the previously captured result is loaded again.
- R5: After the sixteenth rising edge, the data line reads 0, and further serial clock edges keep it at 0 until the next load.
- R6: The serial clock may idle, high or low, for any number of cycles between bits without changing the bit order that is read.
- R7: A falling edge on convert-start while the synchronized serial clock is low clears the word and the bit position, so the data line reads 0 until the next load.
- R8: A falling edge on convert-start while the synchronized serial clock is high leaves the word and the bit position untouched, so the data line keeps its current bit.
- R9: After reset, busy is 0 and the data line is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_start_n | input | 1 | Active-low convert-start strobe; the falling edge starts a conversion |
| sclk | input | 1 | Serial clock from the host; must toggle no faster than once per 3 system clocks |
| result | input | RES_W | Parallel conversion result from the converter core |
| result_valid | input | 1 | One-cycle strobe marking `result` as valid |
| busy | output | 1 | High while a conversion is in progress |
| sdata | output | 1 | Serial data line, MSB first |

## Verification
The readout is swept over 50 result values:
- walking-one values, which reveal any bit that is swapped or stuck low;
- walking-zero values, which reveal any bit stuck high;
- all-zero and all-one values;
- an arithmetic series that mixes the bit positions.

Each value is read as one unbroken run of 16 bits, as two bursts of 8, or as four bursts of 4 with idle gaps between them. Comparing the three read patterns separates a correct position counter from one that drifts across pauses.

Two dedicated cases stop the read partway through the word and then start a conversion: one with the serial clock low and one with it high. This tells a resynchronizing clear apart from one that ignores the state of the clock. A further case gives two valid pulses in one conversion, and another gives none, so that latest-result loading is distinguished from first-result loading and from loading stale data.

// File: rtl/adc_sro_pkg.sv
package adc_sro_pkg;
  // Action applied to the output shift register in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_SHIFT = 2'd3
  } sro_act_e;
endpackage

// File: rtl/sro_rst_sync.sv
module sro_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/sro_sync.sv
module sro_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sro_conv_timer.sv
module sro_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = (CONV_CYCLES < 2) ? 1 : $clog2(CONV_CYCLES + 1);

  logic          busy_q, busy_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = TW'(CONV_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_d = 1'b0;
      done   = 1'b1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sro_shifter.sv
module sro_shifter
  import adc_sro_pkg::*;
#(
  parameter int RES_W  = 14,
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sro_act_e         act,
  input  logic [RES_W-1:0] result,
  input  logic             result_valid,
  output logic             sdata,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam int PAD_W = WORD_W - RES_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [RES_W-1:0]  hold_q, hold_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    hold_d = result_valid ? result : hold_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    unique case (act)
      ACT_LOAD: begin
        sh_d  = {{PAD_W{1'b0}}, hold_d};
        cnt_d = '0;
      end
      ACT_CLEAR: begin
        sh_d  = '0;
        cnt_d = '0;
      end
      ACT_SHIFT: begin
        if (cnt_q != FULL) begin
          sh_d  = {sh_q[WORD_W-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      cnt_q  <= FULL;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sdata   = (cnt_q == FULL) ? 1'b0 : sh_q[WORD_W-1];
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
  import adc_sro_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] result,
  input  logic             result_valid,
  output logic             busy,
  output logic             sdata
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic             rst_sync_n;
  logic             conv_s, sclk_s;
  logic             conv_prev_q, sclk_prev_q;
  logic             conv_fall, sclk_rise, conv_done;
  sro_act_e         act;
  logic [CNT_W-1:0] bit_cnt;

  sro_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  sro_sync #(.STAGES(SYNC_STAGES)) u_sync_conv (
    .clk(clk), .rst_n(rst_sync_n), .d(conv_start_n), .q(conv_s)
  );

  sro_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
    .clk(clk), .rst_n(rst_sync_n), .d(sclk), .q(sclk_s)
  );

  // Previous-value registers for edge detection on synchronized inputs.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      conv_prev_q <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      conv_prev_q <= conv_s;
      sclk_prev_q <= sclk_s;
    end
  end

  assign conv_fall = conv_prev_q & ~conv_s;
  assign sclk_rise = ~sclk_prev_q & sclk_s;

  sro_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(conv_fall),
    .busy(busy), .done(conv_done)
  );

  // Priority: end-of-conversion load, then resync clear, then shift.
  always_comb begin
    act = ACT_HOLD;
    if (conv_done)                act = ACT_LOAD;
    else if (conv_fall && !sclk_s) act = ACT_CLEAR;
    else if (sclk_rise)            act = ACT_SHIFT;
  end

  sro_shifter #(.RES_W(RES_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .act(act), .result(result),
    .result_valid(result_valid), .sdata(sdata), .bit_cnt(bit_cnt)
  );
endmodule

// File: rtl/adc_sro_chk.sv
module adc_sro_chk #(
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             sdata,
  input logic             conv_fall,
  input logic             sclk_s,
  input logic             sclk_rise,
  input logic             conv_done,
  input logic [CNT_W-1:0] bit_cnt
);
  logic [31:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (busy) len_q <= len_q + 1;
    else           len_q <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> len_q == 32'(CONV_CYCLES));

  // R3
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> len_q < 32'(CONV_CYCLES));

  // R1
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sdata && bit_cnt == '0));

  // R2
  change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(sclk_rise || conv_done || conv_fall));

  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt == CNT_W'(WORD_W) |-> !sdata);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(WORD_W));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && !sclk_s) |=> (bit_cnt == '0 && !sdata));

  // R8
  keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && sclk_s && !conv_done && !sclk_rise) |=> ($stable(sdata) && $stable(bit_cnt)));
endmodule

bind adc_serial_readout adc_sro_chk #(
  .WORD_W(WORD_W), .CONV_CYCLES(CONV_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .sdata(sdata),
  .conv_fall(conv_fall), .sclk_s(sclk_s), .sclk_rise(sclk_rise),
  .conv_done(conv_done), .bit_cnt(bit_cnt)
);

// File: tb/tb_adc_serial_readout.sv
module tb_adc_serial_readout;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W      = 14;
  localparam int WORD_W     = 16;
  localparam int CONV       = 12;
  localparam int HALF       = 4;

  logic             clk;
  logic             rst_n;
  logic             conv_start_n;
  logic             sclk;
  logic [RES_W-1:0] result;
  logic             result_valid;
  logic             busy;
  logic             sdata;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  adc_serial_readout #(
    .RES_W(RES_W), .WORD_W(WORD_W), .CONV_CYCLES(CONV), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n), .sclk(sclk),
    .result(result), .result_valid(result_valid), .busy(busy), .sdata(sdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_up();
    sclk = 1'b1;
    wait_sys(HALF);
  endtask

  task automatic sclk_down();
    sclk = 1'b0;
    wait_sys(HALF);
  endtask

  // nvalid: 0 = no pulse, 1 = one pulse with val, 2 = decoy then val.
  // exp_sd >= 0: data line value expected throughout the conversion.
  task automatic start_conv(input int val, input int decoy, input int nvalid, input int exp_sd);
    int t;
    int blen;
    conv_start_n = 1'b0;
    wait_sys(2);
    conv_start_n = 1'b1;
    t = 0;
    while (!busy && t < 20) begin
      wait_sys(1);
      t++;
    end
    blen = 0;
    while (busy && blen < 1000) begin
      result_valid = 1'b0;
      if (nvalid == 2 && blen == 2) begin result = RES_W'(decoy); result_valid = 1'b1; end
      if (nvalid >= 1 && blen == 4) begin result = RES_W'(val);   result_valid = 1'b1; end
      if (exp_sd >= 0 && (blen == 1 || blen == CONV - 2))
        check(sdata == exp_sd[0], "R7/R8 data during conversion", int'(sdata), exp_sd);
      blen++;
      wait_sys(1);
    end
    result_valid = 1'b0;
    check(blen == CONV, "R3 busy length", blen, CONV);
  endtask

  task automatic read_word(input int val, input int burst);
    logic [WORD_W-1:0] w;
    int eb;
    w = WORD_W'(val & ((1 << RES_W) - 1));
    for (int i = 0; i < WORD_W; i++) begin
      if (i > 0 && (i % burst) == 0) begin
        wait_sys(25);
      end
      eb = int'(w[WORD_W-1-i]);
      if (i < 2) check(sdata == 1'b0, "R1 leading zero", int'(sdata), 0);
      else if (burst < WORD_W) check(sdata == w[WORD_W-1-i], "R6 burst bit", int'(sdata), eb);
      else check(sdata == w[WORD_W-1-i], "R2 msb-first bit", int'(sdata), eb);
      sclk_up();
      sclk_down();
    end
    check(sdata == 1'b0, "R5 zero after word", int'(sdata), 0);
    sclk_up();
    sclk_down();
    sclk_up();
    check(sdata == 1'b0, "R5 extra edges", int'(sdata), 0);
    sclk_down();
  endtask

  function automatic int pat(input int k);
    if (k < 14)       return 1 << k;
    else if (k < 28)  return (~(1 << (k - 14))) & 16'h3FFF;
    else if (k == 28) return 0;
    else if (k == 29) return 16'h3FFF;
    else              return (k * 6709 + 291) & 16'h3FFF;
  endfunction

  initial begin
    int b;
    rst_n = 1'b0;
    conv_start_n = 1'b1;
    sclk = 1'b0;
    result = '0;
    result_valid = 1'b0;
    wait_sys(5);
    rst_n = 1'b1;
    wait_sys(4);
    // R9: reset state
    check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
    check(sdata == 1'b0, "R9 sdata after reset", int'(sdata), 0);

    // Sweep of values and burst shapes (R1 R2 R3 R4 R5 R6 R7).
    for (int k = 0; k < 50; k++) begin
      b = (k % 3 == 0) ? 16 : ((k % 3 == 1) ? 8 : 4);
      start_conv(pat(k), 0, 1, 0);
      read_word(pat(k), b);
    end

    // R4: two pulses, the later one wins.
    start_conv(16'h1A5C, 16'h25A3, 2, 0);
    read_word(16'h1A5C, 16);
    // R4: no pulse reloads the last captured result.
    start_conv(0, 0, 0, 0);
    read_word(16'h1A5C, 8);

    // R7: resync clear with the serial clock low, partway through a word.
    start_conv(16'h0800, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin sclk_up(); sclk_down(); end
    check(sdata == 1'b1, "R7 setup bit 11", int'(sdata), 1);
    start_conv(16'h1357, 0, 1, 0);
    read_word(16'h1357, 16);

    // R8: no clear with the serial clock high, partway through a word.
    start_conv(16'h0800, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin sclk_up(); sclk_down(); end
    sclk_up();
    check(sdata == 1'b1, "R8 setup bit 11", int'(sdata), 1);
    start_conv(16'h2C61, 0, 1, 1);
    sclk_down();
    read_word(16'h2C61, 4);

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule